// File: doc/BRIEF.md
# Hot-Plug Slot Controller

This block holds the slot command and slot status registers of a hot-plug capable downstream or root port, and turns slot events into interrupts. Software reaches both 16-bit registers through a small write/read port with one byte enable per byte lane. Every write to the command register is one command: its actions take effect at once and command-completed is raised in the same update.

The slot side gives three single-cycle event inputs: a device was attached, a device asks to be removed, and the attention button was pressed. When software powers off a populated slot with its power indicator off, the block pulses a detach-request output and marks the slot empty. A notification condition is formed from the enables and the status bits. The block reports only changes of that condition: as a one-cycle message request carrying a vector when messages are enabled, or on a level interrupt output when they are not.

Top module: `hp_slot_ctrl`

## Requirements
- R1: While reset is held on a clock edge, the command register becomes attention indicator off (bits 7:6 = 11), all enables 0, and, with a power controller fitted, either power on with power indicator on (bits 10:8 = 001) when `present_at_reset` is 1, or power off with power indicator off (bits 10:8 = 111) when it is 0. Status holds only presence state (bit 6) = `present_at_reset`. `irq_level`, `msg_req` and `detach_req` are 0.
- R2: A command write updates, byte lane by byte lane, the fields attention-button enable (bit 0), presence-change enable (bit 3), command-done enable (bit 4), hot-plug interrupt enable (bit 5), attention indicator (7:6), power indicator (9:8) and power-off control (bit 10); lanes with a clear enable keep their value, and every other bit reads 0.
- R3: A command write carrying 1 in bit 11 with the upper lane enabled toggles interlock-engaged status (bit 7); bit 11 of the command register always reads 0.
- R4: Every command write sets command-completed status (bit 4) in the same update as its other actions.
- R5: When presence state is 1 and a command write leaves bit 10 at 1 and bits 9:8 at 11, `detach_req` pulses for one cycle, presence state clears and presence-changed (bit 3) sets; with presence state 0 no pulse occurs.
- R6: An attach pulse sets presence state, presence-changed and attention-button-pressed (bit 0).
- R7: A removal-request pulse or an attention-button pulse sets attention-button-pressed only.
- R8: Status bits 0, 3 and 4 clear when written with 1 in the lower lane; writes to bits 6 and 7 and all other status bits have no effect.
- R9: The notification condition is hot-plug interrupt enable AND any of status bits 0, 3, 4 set with its matching enable set. With messages disabled, `irq_level` takes the condition's value whenever it changes or the status register is written.
- R10: With messages enabled, each change of the condition, in either direction, gives a one-cycle `msg_req` with `msg_vec` equal to `msg_vector`, and `irq_level` does not change.
- R11: An event that sets a status bit already set, or any update that leaves the condition unchanged, produces no `msg_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| present_at_reset | input | 1 | A device sits in the slot while reset is held |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects command register, 1 selects status register |
| reg_be | input | 2 | Byte-lane enables of the write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| dev_attach | input | 1 | Hot-add event pulse |
| remove_req | input | 1 | Hot-removal request pulse |
| atten_btn | input | 1 | Attention button pulse |
| msg_en | input | 1 | Messages enabled instead of level interrupt |
| msg_vector | input | VEC_W | Vector to attach to message requests |
| irq_level | output | 1 | Level interrupt |
| msg_req | output | 1 | One-cycle message request |
| msg_vec | output | VEC_W | Vector of the current message request |
| detach_req | output | 1 | One-cycle request to detach the slot's device |

## Verification
Every result of this block is due one clock edge after its stimulus: register contents, the interrupt level, the message pulse and the detach pulse all come out of flops loaded at the edge that samples the write or event. The bench drives inputs on the falling edge, keeps them for one rising edge and samples at the next falling edge, where pulses are checked present; one cycle later it checks that they are gone. Register contents are read back through the combinational read port half a cycle after the update.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
   localparam int REG_W = 16;

   // status bit positions
   localparam int ST_BTN  = 0;
   localparam int ST_PCHG = 3;
   localparam int ST_DONE = 4;
   localparam int ST_PRES = 6;
   localparam int ST_LOCK = 7;

   // command bit positions
   localparam int CM_BTN_EN  = 0;
   localparam int CM_PCHG_EN = 3;
   localparam int CM_DONE_EN = 4;
   localparam int CM_HP_EN   = 5;
   localparam int CM_ATTN_LO = 6;
   localparam int CM_PWRI_LO = 8;
   localparam int CM_PWROFF  = 10;
   localparam int CM_LOCK    = 11;

   typedef enum logic [1:0] {
      IND_RSVD  = 2'b00,
      IND_ON    = 2'b01,
      IND_BLINK = 2'b10,
      IND_OFF   = 2'b11
   } ind_e;

   localparam logic [REG_W-1:0] EVT_MASK =
      (16'd1 << ST_BTN) | (16'd1 << ST_PCHG) | (16'd1 << ST_DONE);
   localparam logic [REG_W-1:0] CMD_BASE_MASK = 16'h03F9;
endpackage

// File: rtl/hp_slot_cmd_reg.sv
module hp_slot_cmd_reg
   import hp_slot_pkg::*;
#(
   parameter bit HAS_PWR_CTL = 1'b1,
   parameter int LANES       = REG_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             present_at_reset,
   input  logic             wr_en,
   input  logic [LANES-1:0] be,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] cmd_q,
   output logic [REG_W-1:0] cmd_nxt,
   output logic             lock_hit
);
   localparam logic [REG_W-1:0] WMASK =
      HAS_PWR_CTL ? (CMD_BASE_MASK | (16'd1 << CM_PWROFF)) : CMD_BASE_MASK;

   logic [REG_W-1:0] rst_val;

   if (REG_W != 16) begin : g_bad_width
      $error("hp_slot_cmd_reg: register width must be 16");
   end

   if (HAS_PWR_CTL) begin : g_pwr
      always_comb begin
         rst_val = '0;
         rst_val[CM_ATTN_LO +: 2] = IND_OFF;
         rst_val[CM_PWRI_LO +: 2] = present_at_reset ? IND_ON : IND_OFF;
         rst_val[CM_PWROFF]       = ~present_at_reset;
      end
   end else begin : g_nopwr
      always_comb begin
         rst_val = '0;
         rst_val[CM_ATTN_LO +: 2] = IND_OFF;
      end
   end

   always_comb begin
      cmd_nxt = cmd_q;
      if (wr_en) begin
         for (int i = 0; i < LANES; i++) begin
            if (be[i]) cmd_nxt[i*8 +: 8] = wdata[i*8 +: 8] & WMASK[i*8 +: 8];
         end
      end
   end

   assign lock_hit = wr_en && be[CM_LOCK/8] && wdata[CM_LOCK];

   always_ff @(posedge clk) begin
      if (!rst_n) cmd_q <= rst_val;
      else        cmd_q <= cmd_nxt;
   end

   AST_LOCK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      lock_hit |=> !cmd_q[CM_LOCK]); // R3
endmodule

// File: rtl/hp_slot_sts_reg.sv
module hp_slot_sts_reg
   import hp_slot_pkg::*;
#(
   parameter int LANES = REG_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             present_at_reset,
   input  logic             wr_en,
   input  logic             cmd_wr,
   input  logic [LANES-1:0] be,
   input  logic [REG_W-1:0] wdata,
   input  logic [REG_W-1:0] cmd_nxt,
   input  logic             lock_hit,
   input  logic             attach,
   input  logic             remove,
   input  logic             button,
   output logic [REG_W-1:0] sts_q,
   output logic [REG_W-1:0] sts_nxt,
   output logic             detach_q
);
   logic [REG_W-1:0] clr_mask;
   logic             power_off_cmd;

   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         clr_mask[i*8 +: 8] = (wr_en && be[i]) ? (wdata[i*8 +: 8] & EVT_MASK[i*8 +: 8]) : 8'h00;
      end
   end

   assign power_off_cmd = cmd_wr && sts_q[ST_PRES] && cmd_nxt[CM_PWROFF] &&
                          (cmd_nxt[CM_PWRI_LO +: 2] == IND_OFF);

   always_comb begin
      sts_nxt = sts_q & ~clr_mask;
      if (lock_hit) sts_nxt[ST_LOCK] = ~sts_q[ST_LOCK];
      if (power_off_cmd) begin
         sts_nxt[ST_PRES] = 1'b0;
         sts_nxt[ST_PCHG] = 1'b1;
      end
      if (cmd_wr) sts_nxt[ST_DONE] = 1'b1;
      if (attach) begin
         sts_nxt[ST_PRES] = 1'b1;
         sts_nxt[ST_PCHG] = 1'b1;
      end
      if (attach || remove || button) sts_nxt[ST_BTN] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_q           <= '0;
         sts_q[ST_PRES]  <= present_at_reset;
         detach_q        <= 1'b0;
      end else begin
         sts_q    <= sts_nxt;
         detach_q <= power_off_cmd;
      end
   end

   AST_CMD_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |=> sts_q[ST_DONE]); // R4
   AST_LOCK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      lock_hit |=> (sts_q[ST_LOCK] != $past(sts_q[ST_LOCK]))); // R3
   AST_DETACH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      detach_q |-> (!sts_q[ST_PRES] && sts_q[ST_PCHG])); // R5
   AST_ATTACH_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
      attach |=> (sts_q[ST_PRES] && sts_q[ST_PCHG] && sts_q[ST_BTN])); // R6
   AST_W1C_BUTTON: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && be[0] && wdata[ST_BTN] && !attach && !remove && !button) |=> !sts_q[ST_BTN]); // R8
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
   import hp_slot_pkg::*;
#(
   parameter int VEC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] cmd_nxt,
   input  logic [REG_W-1:0] sts_nxt,
   input  logic             sts_wr,
   input  logic             msg_en,
   input  logic [VEC_W-1:0] msg_vector,
   output logic             irq_level,
   output logic             msg_req,
   output logic [VEC_W-1:0] msg_vec
);
   logic cond_nxt, cond_q, chg;

   if (VEC_W < 1 || VEC_W > 5) begin : g_bad_vec
      $error("hp_slot_notify: VEC_W must be 1 to 5");
   end

   assign cond_nxt = cmd_nxt[CM_HP_EN] && |(sts_nxt & cmd_nxt & EVT_MASK);
   assign chg      = cond_nxt != cond_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cond_q    <= 1'b0;
         irq_level <= 1'b0;
         msg_req   <= 1'b0;
         msg_vec   <= '0;
      end else begin
         cond_q  <= cond_nxt;
         msg_req <= msg_en && chg;
         if (msg_en && chg) msg_vec <= msg_vector;
         if (!msg_en && (chg || sts_wr)) irq_level <= cond_nxt;
      end
   end

   AST_MSG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      msg_req |-> (cond_q != $past(cond_q))); // R10
   AST_IRQ_ONLY_LEVEL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(irq_level) |-> !$past(msg_en)); // R9
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
   import hp_slot_pkg::*;
#(
   parameter int VEC_W       = 5,
   parameter bit HAS_PWR_CTL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             present_at_reset,
   input  logic             reg_wr,
   input  logic             reg_sel,
   input  logic [1:0]       reg_be,
   input  logic [15:0]      reg_wdata,
   output logic [15:0]      reg_rdata,
   input  logic             dev_attach,
   input  logic             remove_req,
   input  logic             atten_btn,
   input  logic             msg_en,
   input  logic [VEC_W-1:0] msg_vector,
   output logic             irq_level,
   output logic             msg_req,
   output logic [VEC_W-1:0] msg_vec,
   output logic             detach_req
);
   logic             cmd_wr, sts_wr, lock_hit;
   logic [REG_W-1:0] cmd_q, cmd_nxt, sts_q, sts_nxt;

   assign cmd_wr = reg_wr && !reg_sel && (|reg_be);
   assign sts_wr = reg_wr &&  reg_sel && (|reg_be);

   hp_slot_cmd_reg #(.HAS_PWR_CTL(HAS_PWR_CTL)) u_cmd (
      .clk(clk), .rst_n(rst_n), .present_at_reset(present_at_reset),
      .wr_en(cmd_wr), .be(reg_be), .wdata(reg_wdata),
      .cmd_q(cmd_q), .cmd_nxt(cmd_nxt), .lock_hit(lock_hit));

   hp_slot_sts_reg u_sts (
      .clk(clk), .rst_n(rst_n), .present_at_reset(present_at_reset),
      .wr_en(sts_wr), .cmd_wr(cmd_wr), .be(reg_be), .wdata(reg_wdata),
      .cmd_nxt(cmd_nxt), .lock_hit(lock_hit),
      .attach(dev_attach), .remove(remove_req), .button(atten_btn),
      .sts_q(sts_q), .sts_nxt(sts_nxt), .detach_q(detach_req));

   hp_slot_notify #(.VEC_W(VEC_W)) u_ntf (
      .clk(clk), .rst_n(rst_n), .cmd_nxt(cmd_nxt), .sts_nxt(sts_nxt),
      .sts_wr(sts_wr), .msg_en(msg_en), .msg_vector(msg_vector),
      .irq_level(irq_level), .msg_req(msg_req), .msg_vec(msg_vec));

   assign reg_rdata = reg_sel ? sts_q : cmd_q;

   AST_DETACH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      detach_req |=> !detach_req); // R5
   AST_NO_MSG_WHEN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !msg_en |=> !msg_req); // R10
endmodule

// File: tb/hp_slot_ctrl_bench.sv
`timescale 1ns/100ps
module hp_slot_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        present_at_reset = 1'b1;
   logic        reg_wr = 1'b0, reg_sel = 1'b0;
   logic [1:0]  reg_be = 2'b00;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        dev_attach = 1'b0, remove_req = 1'b0, atten_btn = 1'b0;
   logic        msg_en = 1'b0;
   logic [4:0]  msg_vector = '0;
   logic        irq_level, msg_req, detach_req;
   logic [4:0]  msg_vec;
   int          checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   hp_slot_ctrl u_hp_slot_ctrl (
      .clk(clk), .rst_n(rst_n), .present_at_reset(present_at_reset),
      .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_be(reg_be), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .dev_attach(dev_attach), .remove_req(remove_req),
      .atten_btn(atten_btn), .msg_en(msg_en), .msg_vector(msg_vector),
      .irq_level(irq_level), .msg_req(msg_req), .msg_vec(msg_vec),
      .detach_req(detach_req));

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic sel, output logic [15:0] v);
      reg_sel = sel;
      #1 v = reg_rdata;
   endtask

   // drive on a falling edge, hold over one rising edge, return on the next falling edge
   task automatic wr(input logic sel, input logic [1:0] be, input logic [15:0] d);
      @(negedge clk);
      reg_sel = sel; reg_be = be; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_be = 2'b00;
   endtask

   task automatic ev(input int which);
      @(negedge clk);
      dev_attach = (which == 0); remove_req = (which == 1); atten_btn = (which == 2);
      @(negedge clk);
      dev_attach = 1'b0; remove_req = 1'b0; atten_btn = 1'b0;
   endtask

   task automatic do_reset(input logic pres);
      @(negedge clk);
      present_at_reset = pres; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_present;
      logic [15:0] v;
      do_reset(1'b1);
      rd(1'b0, v); chk("R1 command after reset, present", v, 16'h01C0);
      rd(1'b1, v); chk("R1 status after reset, present", v, 16'h0040);
      chk("R1 irq after reset", {15'd0, irq_level}, 16'd0);
      chk("R1 msg_req after reset", {15'd0, msg_req}, 16'd0);
      chk("R1 detach after reset", {15'd0, detach_req}, 16'd0);
   endtask

   task automatic t_cmd_write;
      logic [15:0] v;
      wr(1'b0, 2'b11, 16'hF1F9);
      rd(1'b0, v); chk("R2 writable fields only", v, 16'h01F9);
      rd(1'b1, v); chk("R4 command completed set", v, 16'h0050);
      chk("R9 irq follows condition high", {15'd0, irq_level}, 16'd1);
      wr(1'b1, 2'b01, 16'h00D0);
      rd(1'b1, v); chk("R8 W1C clears done, bits 6/7 ignored", v, 16'h0040);
      chk("R9 irq low after status write", {15'd0, irq_level}, 16'd0);
      wr(1'b0, 2'b10, 16'h00FF);
      rd(1'b0, v); chk("R2 upper lane only", v, 16'h00F9);
      wr(1'b1, 2'b01, 16'h0010);
   endtask

   task automatic t_lock;
      logic [15:0] v;
      wr(1'b0, 2'b10, 16'h0800);
      rd(1'b0, v); chk("R3 lock control reads 0", v, 16'h00F9);
      rd(1'b1, v); chk("R3 lock engaged toggled on", v, 16'h00D0);
      chk("R9 irq high from done event", {15'd0, irq_level}, 16'd1);
      wr(1'b0, 2'b10, 16'h0800);
      rd(1'b1, v); chk("R3 lock engaged toggled off", v, 16'h0050);
      chk("R9 irq stays high", {15'd0, irq_level}, 16'd1);
      wr(1'b0, 2'b01, 16'h08FF);
      rd(1'b1, v); chk("R3 lower lane does not toggle", v, 16'h0050);
      wr(1'b1, 2'b01, 16'h0010);
      chk("R9 irq cleared", {15'd0, irq_level}, 16'd0);
   endtask

   task automatic t_no_done_enable;
      logic [15:0] v;
      wr(1'b0, 2'b11, 16'h00E9);
      rd(1'b1, v); chk("R4 done set with enable off", v, 16'h0050);
      chk("R9 no irq without matching enable", {15'd0, irq_level}, 16'd0);
      wr(1'b1, 2'b01, 16'h0010);
   endtask

   task automatic t_messages;
      logic [15:0] v;
      msg_en = 1'b1; msg_vector = 5'd19;
      ev(2);
      rd(1'b1, v); chk("R7 button sets pressed only", v, 16'h0041);
      chk("R10 message on rise", {15'd0, msg_req}, 16'd1);
      chk("R10 message vector", {11'd0, msg_vec}, 16'd19);
      chk("R10 irq untouched", {15'd0, irq_level}, 16'd0);
      @(negedge clk);
      chk("R10 message one cycle", {15'd0, msg_req}, 16'd0);
      ev(2);
      chk("R11 repeated event, no message", {15'd0, msg_req}, 16'd0);
      wr(1'b1, 2'b01, 16'h0001);
      chk("R10 message on fall", {15'd0, msg_req}, 16'd1);
      ev(1);
      rd(1'b1, v); chk("R7 removal request sets pressed only", v, 16'h0041);
      chk("R10 message for removal request", {15'd0, msg_req}, 16'd1);
      wr(1'b1, 2'b01, 16'h0001);
   endtask

   task automatic t_detach;
      logic [15:0] v;
      wr(1'b0, 2'b11, 16'h07E9);
      chk("R5 detach pulse", {15'd0, detach_req}, 16'd1);
      rd(1'b1, v); chk("R5 presence cleared, changed set", v, 16'h0018);
      chk("R10 message on presence change", {15'd0, msg_req}, 16'd1);
      @(negedge clk);
      chk("R5 detach one cycle", {15'd0, detach_req}, 16'd0);
      wr(1'b1, 2'b01, 16'h0018);
      rd(1'b1, v); chk("R8 W1C two bits", v, 16'h0000);
      wr(1'b0, 2'b11, 16'h07E9);
      chk("R5 empty slot, no detach", {15'd0, detach_req}, 16'd0);
      chk("R11 condition unchanged, no message", {15'd0, msg_req}, 16'd0);
      wr(1'b1, 2'b01, 16'h0010);
   endtask

   task automatic t_attach;
      logic [15:0] v;
      msg_en = 1'b0;
      ev(0);
      rd(1'b1, v); chk("R6 attach events", v, 16'h0049);
      chk("R9 irq from attach", {15'd0, irq_level}, 16'd1);
      wr(1'b1, 2'b01, 16'h0009);
      rd(1'b1, v); chk("R8 cleared, presence kept", v, 16'h0040);
      chk("R9 irq deasserted", {15'd0, irq_level}, 16'd0);
   endtask

   task automatic t_reset_empty;
      logic [15:0] v;
      do_reset(1'b0);
      rd(1'b0, v); chk("R1 command after reset, empty", v, 16'h07C0);
      rd(1'b1, v); chk("R1 status after reset, empty", v, 16'h0000);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset_present();
      t_cmd_write();
      t_lock();
      t_no_done_enable();
      t_messages();
      t_detach();
      t_attach();
      t_reset_empty();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule